// File: doc/BRIEF.md
# Lithium Cell CC-CV Charge Controller

This block supervises the charging of a single lithium cell. An external converter samples four analog quantities and presents them as unsigned codes: cell voltage, charge current, charger input voltage and cell temperature. The controller decides whether the analog charger stage runs at all. When it runs, the controller selects between regulating current and regulating voltage. It raises a flag when the cell counts as full, and a flag when it has stopped for a fault or is waiting on temperature.

The charge begins in constant-current mode. It moves to constant-voltage mode once the cell reaches the target voltage. While in constant-voltage mode, two separate current limits apply. The higher limit lights the full flag and charging carries on. The lower limit ends the charge. A finished cell is topped up again once its voltage sags to a lower recharge level.

A temperature window gates all charging. When the temperature leaves the window, the charge pauses and later resumes in the phase it left. A one-second tick drives a safety timer that aborts an overlong charge.

Code scales: cell and input voltage are 5 mV per LSB, so 4.20 V is 840 and 4.05 V is 810. Current is 1 mA per LSB. Temperature code equals degrees Celsius plus 50, so -2 °C is 48 and 47 °C is 97.

Top module: `cccv_charger`

## Requirements
- R1: While rstN is low, every output (ccEn, cvEn, chargeEn, fullFlag, faultFlag, tempHold) is 0, whatever the inputs.
- R2: The charger counts as present when chgInV >= 840. With the charger present and the temperature in the window, an idle controller enters constant-current mode (ccEn=1, chargeEn=1). With chgInV at 839 it stays idle.
- R3: Constant-current mode hands over to constant-voltage mode (cvEn=1, ccEn=0, chargeEn=1) when batV >= 840. At batV=839 it stays in constant-current mode.
- R4: fullFlag rises only in constant-voltage mode, when chgI < 100, and charging continues. chgI=100 does not raise it, and a low current in constant-current mode does not raise it either.
- R5: In constant-voltage mode, chgI < 50 ends the charge (chargeEn=0, ccEn=0, cvEn=0) and fullFlag stays 1. chgI=50 does not end it.
- R6: After the charge has ended, batV <= 810 starts a new charge in constant-current mode and clears fullFlag. batV=811 does not.
- R7: Charging is allowed only while 48 <= batTemp <= 97. Outside that window the controller pauses with chargeEn=0 and tempHold=1.
- R8: When the temperature returns to the window, a paused charge resumes in the mode it paused from, constant-current or constant-voltage.
- R9: The safety timer counts secTick pulses only while the controller is in constant-current or constant-voltage mode. The count is cleared at the start of each charge. When the count reaches SAFETY_SECONDS, charging stops with faultFlag=1. The fault holds for as long as the charger stays present.
- R10: When chgInV falls below 840, the controller returns to idle from any state and clears fullFlag and faultFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle pulse once per second |
| batV | input | ADC_W | Cell voltage code |
| chgI | input | ADC_W | Charge current code |
| chgInV | input | ADC_W | Charger input voltage code |
| batTemp | input | ADC_W | Cell temperature code |
| ccEn | output | 1 | Constant-current regulation active |
| cvEn | output | 1 | Constant-voltage regulation active |
| chargeEn | output | 1 | Charger stage enabled |
| fullFlag | output | 1 | Cell counted as full |
| faultFlag | output | 1 | Safety timer abort |
| tempHold | output | 1 | Paused on temperature |

## Verification
The hardest condition to reach from the ports is a safety-timer expiry that depends on where the seconds were spent. Ticks that arrive during a temperature pause must not count, and the count must clear between charges. The stimulus builds a charge with 39 ticks spent charging and checks that it survives. It then adds the 40th tick, with the bench's shortened limit, and checks for the fault. A separate charge spends 50 ticks paused and then 39 charging, and must not fault.

// File: rtl/cccv_pkg.sv
package cccv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CC,
    ST_CV,
    ST_DONE,
    ST_HOLD,
    ST_FAULT
  } chgState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic timerRun;
    logic fullSet;
    logic fullClr;
  } ctlStrobe_t;

  // compare results from datapath to control
  typedef struct packed {
    logic chgPresent;
    logic tempOk;
    logic reachedCv;
    logic belowFull;
    logic belowTerm;
    logic needRecharge;
    logic timerExpired;
  } dpStatus_t;

endpackage

// File: rtl/cccv_datapath.sv
module cccv_datapath
  import cccv_pkg::*;
#(
  parameter int ADC_W          = 10,
  parameter int V_DETECT       = 840,
  parameter int V_CV           = 840,
  parameter int V_RECHARGE     = 810,
  parameter int I_FULL         = 100,
  parameter int I_TERM         = 50,
  parameter int T_MIN          = 48,
  parameter int T_MAX          = 97,
  parameter int SAFETY_SECONDS = 10800
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  logic [ADC_W-1:0] batV,
  input  logic [ADC_W-1:0] chgI,
  input  logic [ADC_W-1:0] chgInV,
  input  logic [ADC_W-1:0] batTemp,
  input  ctlStrobe_t       strobe,
  output dpStatus_t        status,
  output logic             fullFlag
);

  localparam int CNT_W = $clog2(SAFETY_SECONDS + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(SAFETY_SECONDS);

  logic [CNT_W-1:0] secCount;
  logic             expired;

  assign expired = (secCount >= CNT_LIMIT);

  always_comb begin
    status.chgPresent   = (chgInV >= ADC_W'(V_DETECT));
    status.tempOk       = (batTemp >= ADC_W'(T_MIN)) && (batTemp <= ADC_W'(T_MAX));
    status.reachedCv    = (batV >= ADC_W'(V_CV));
    status.belowFull    = (chgI < ADC_W'(I_FULL));
    status.belowTerm    = (chgI < ADC_W'(I_TERM));
    status.needRecharge = (batV <= ADC_W'(V_RECHARGE));
    status.timerExpired = expired;
  end

  // safety timer, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secCount <= '0;
    end else if (strobe.timerClr) begin
      secCount <= '0;
    end else if (strobe.timerRun && secTick && !expired) begin
      secCount <= secCount + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullFlag <= 1'b0;
    end else if (strobe.fullClr) begin
      fullFlag <= 1'b0;
    end else if (strobe.fullSet) begin
      fullFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/cccv_control.sv
module cccv_control
  import cccv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       ccEn,
  output logic       cvEn,
  output logic       faultFlag,
  output logic       tempHold
);

  chgState_t state, stateNxt;
  logic      resumeCv, resumeCvNxt;

  always_comb begin
    stateNxt    = state;
    resumeCvNxt = resumeCv;
    strobe      = '0;
    if (!status.chgPresent) begin
      stateNxt       = ST_IDLE;
      strobe.fullClr = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          strobe.timerClr = 1'b1;
          resumeCvNxt     = 1'b0;
          stateNxt        = status.tempOk ? ST_CC : ST_HOLD;
        end
        ST_CC: begin
          strobe.timerRun = 1'b1;
          if (status.timerExpired) begin
            stateNxt = ST_FAULT;
          end else if (!status.tempOk) begin
            stateNxt    = ST_HOLD;
            resumeCvNxt = 1'b0;
          end else if (status.reachedCv) begin
            stateNxt = ST_CV;
          end
        end
        ST_CV: begin
          strobe.timerRun = 1'b1;
          if (status.timerExpired) begin
            stateNxt = ST_FAULT;
          end else if (!status.tempOk) begin
            stateNxt    = ST_HOLD;
            resumeCvNxt = 1'b1;
          end else begin
            strobe.fullSet = status.belowFull;
            if (status.belowTerm) begin
              stateNxt = ST_DONE;
            end
          end
        end
        ST_DONE: begin
          if (status.needRecharge) begin
            strobe.timerClr = 1'b1;
            strobe.fullClr  = 1'b1;
            resumeCvNxt     = 1'b0;
            stateNxt        = status.tempOk ? ST_CC : ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (status.tempOk) begin
            stateNxt = resumeCv ? ST_CV : ST_CC;
          end
        end
        ST_FAULT: stateNxt = ST_FAULT;
        default:  stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      resumeCv <= 1'b0;
    end else begin
      state    <= stateNxt;
      resumeCv <= resumeCvNxt;
    end
  end

  assign ccEn      = (state == ST_CC);
  assign cvEn      = (state == ST_CV);
  assign faultFlag = (state == ST_FAULT);
  assign tempHold  = (state == ST_HOLD);

endmodule

// File: rtl/cccv_charger.sv
module cccv_charger
  import cccv_pkg::*;
#(
  parameter int ADC_W          = 10,
  parameter int V_DETECT       = 840,
  parameter int V_CV           = 840,
  parameter int V_RECHARGE     = 810,
  parameter int I_FULL         = 100,
  parameter int I_TERM         = 50,
  parameter int T_MIN          = 48,
  parameter int T_MAX          = 97,
  parameter int SAFETY_SECONDS = 10800
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  logic [ADC_W-1:0] batV,
  input  logic [ADC_W-1:0] chgI,
  input  logic [ADC_W-1:0] chgInV,
  input  logic [ADC_W-1:0] batTemp,
  output logic             ccEn,
  output logic             cvEn,
  output logic             chargeEn,
  output logic             fullFlag,
  output logic             faultFlag,
  output logic             tempHold
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  cccv_datapath #(
    .ADC_W(ADC_W), .V_DETECT(V_DETECT), .V_CV(V_CV), .V_RECHARGE(V_RECHARGE),
    .I_FULL(I_FULL), .I_TERM(I_TERM), .T_MIN(T_MIN), .T_MAX(T_MAX),
    .SAFETY_SECONDS(SAFETY_SECONDS)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .batV(batV), .chgI(chgI), .chgInV(chgInV), .batTemp(batTemp),
    .strobe(strobe), .status(status), .fullFlag(fullFlag)
  );

  cccv_control u_control (
    .clk(clk), .rstN(rstN), .status(status), .strobe(strobe),
    .ccEn(ccEn), .cvEn(cvEn), .faultFlag(faultFlag), .tempHold(tempHold)
  );

  assign chargeEn = ccEn | cvEn;

endmodule

// File: rtl/cccv_charger_checker.sv
module cccv_charger_checker #(
  parameter int ADC_W    = 10,
  parameter int V_DETECT = 840,
  parameter int V_CV     = 840,
  parameter int T_MIN    = 48,
  parameter int T_MAX    = 97
) (
  input logic             clk,
  input logic             rstN,
  input logic [ADC_W-1:0] batV,
  input logic [ADC_W-1:0] chgInV,
  input logic [ADC_W-1:0] batTemp,
  input logic             ccEn,
  input logic             cvEn,
  input logic             chargeEn,
  input logic             fullFlag,
  input logic             faultFlag,
  input logic             tempHold
);

  // modes exclusive
  p_mode_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ccEn, cvEn, faultFlag, tempHold}));

  p_cv_entry_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cvEn) |-> ($past(batV) >= ADC_W'(V_CV)) || $past(tempHold));

  p_full_from_cv_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> $past(cvEn));

  p_temp_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((batTemp < ADC_W'(T_MIN)) || (batTemp > ADC_W'(T_MAX))) |=> !chargeEn);

  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && (chgInV >= ADC_W'(V_DETECT))) |=> faultFlag);

  p_unplug_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (chgInV < ADC_W'(V_DETECT)) |=> (!chargeEn && !fullFlag && !faultFlag && !tempHold));

endmodule

bind cccv_charger cccv_charger_checker #(
  .ADC_W(ADC_W), .V_DETECT(V_DETECT), .V_CV(V_CV), .T_MIN(T_MIN), .T_MAX(T_MAX)
) u_checker (
  .clk(clk), .rstN(rstN), .batV(batV), .chgInV(chgInV), .batTemp(batTemp),
  .ccEn(ccEn), .cvEn(cvEn), .chargeEn(chargeEn), .fullFlag(fullFlag),
  .faultFlag(faultFlag), .tempHold(tempHold)
);

// File: tb/cccv_charger_bench.sv
`timescale 1ns/1ps
module cccv_charger_bench;

  localparam int W = 10;
  localparam int LIMIT = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0;
  logic [W-1:0] batV = '0, chgI = '0, chgInV = '0, batTemp = 10'd75;
  logic ccEn, cvEn, chargeEn, fullFlag, faultFlag, tempHold;

  int checkCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  cccv_charger #(.SAFETY_SECONDS(LIMIT)) u_cccv_charger (
    .clk(clk), .rstN(rstN), .secTick(secTick),
    .batV(batV), .chgI(chgI), .chgInV(chgInV), .batTemp(batTemp),
    .ccEn(ccEn), .cvEn(cvEn), .chargeEn(chargeEn), .fullFlag(fullFlag),
    .faultFlag(faultFlag), .tempHold(tempHold)
  );

  // expected bits: {ccEn, cvEn, chargeEn, fullFlag, faultFlag, tempHold}
  typedef struct packed {
    logic [W-1:0] bat;
    logic [W-1:0] cur;
    logic [W-1:0] vin;
    logic [W-1:0] tmp;
    logic [5:0]   exp;
    logic [3:0]   req;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{10'd760, 10'd0,   10'd0,   10'd75, 6'b000000, 4'd2},  // R2 no charger
    '{10'd760, 10'd0,   10'd839, 10'd75, 6'b000000, 4'd2},  // R2 just below detect
    '{10'd760, 10'd500, 10'd840, 10'd75, 6'b101000, 4'd2},  // R2 enter CC
    '{10'd839, 10'd60,  10'd840, 10'd75, 6'b101000, 4'd3},  // R3 below CV, R4 no full in CC
    '{10'd840, 10'd500, 10'd840, 10'd75, 6'b011000, 4'd3},  // R3 enter CV
    '{10'd840, 10'd500, 10'd840, 10'd98, 6'b000001, 4'd7},  // R7 too hot
    '{10'd840, 10'd500, 10'd840, 10'd97, 6'b011000, 4'd8},  // R8 resume CV
    '{10'd840, 10'd100, 10'd840, 10'd97, 6'b011000, 4'd4},  // R4 boundary
    '{10'd840, 10'd99,  10'd840, 10'd75, 6'b011100, 4'd4},  // R4 full
    '{10'd840, 10'd50,  10'd840, 10'd75, 6'b011100, 4'd5},  // R5 boundary
    '{10'd840, 10'd49,  10'd840, 10'd75, 6'b000100, 4'd5},  // R5 terminate
    '{10'd811, 10'd0,   10'd840, 10'd75, 6'b000100, 4'd6},  // R6 boundary
    '{10'd810, 10'd300, 10'd840, 10'd75, 6'b101000, 4'd6},  // R6 recharge
    '{10'd810, 10'd300, 10'd840, 10'd47, 6'b000001, 4'd7},  // R7 too cold
    '{10'd810, 10'd300, 10'd840, 10'd48, 6'b101000, 4'd8},  // R8 resume CC
    '{10'd810, 10'd300, 10'd0,   10'd48, 6'b000000, 4'd10}  // R10 unplug
  };

  task automatic setIn(input int b, input int c, input int v, input int t);
    batV = W'(b); chgI = W'(c); chgInV = W'(v); batTemp = W'(t);
  endtask

  task automatic waitCycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      secTick = 1'b1;
      @(negedge clk);
      secTick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {ccEn, cvEn, chargeEn, fullFlag, faultFlag, tempHold};
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: outputs %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #(100000 * 20);
    failCount++;
    checkCount++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    // R1: reset state with a charger present
    setIn(760, 500, 900, 75);
    waitCycles(3);
    check("R1", 6'b000000);
    @(negedge clk);
    rstN = 1'b1;
    setIn(760, 0, 0, 75);
    waitCycles(2);

    for (int i = 0; i < 16; i++) begin
      setIn(int'(VECS[i].bat), int'(VECS[i].cur), int'(VECS[i].vin), int'(VECS[i].tmp));
      waitCycles(2);
      check($sformatf("R%0d step %0d", VECS[i].req, i), VECS[i].exp);
    end

    // R9: expiry after the limit
    setIn(760, 500, 900, 75);
    waitCycles(2);
    tick(LIMIT - 1);
    waitCycles(2);
    check("R9 one tick short", 6'b101000);
    tick(1);
    waitCycles(2);
    check("R9 expired", 6'b000010);
    setIn(760, 500, 900, 20);
    waitCycles(2);
    check("R9 fault held", 6'b000010);
    setIn(760, 500, 0, 20);
    waitCycles(2);
    check("R10 fault cleared", 6'b000000);

    // R9: ticks during a pause do not count, count cleared per charge
    setIn(760, 500, 900, 75);
    waitCycles(2);
    setIn(760, 500, 900, 20);
    waitCycles(2);
    tick(50);
    setIn(760, 500, 900, 75);
    waitCycles(2);
    check("R9 pause ticks ignored", 6'b101000);
    tick(LIMIT - 1);
    waitCycles(2);
    check("R9 charge ticks only", 6'b101000);
    setIn(760, 500, 0, 75);
    waitCycles(2);

    // R5 then R10: unplug clears the full flag
    setIn(840, 30, 900, 75);
    waitCycles(4);
    check("R5 direct to done", 6'b000100);
    setIn(840, 30, 0, 75);
    waitCycles(2);
    check("R10 full cleared", 6'b000000);

    // R1: reset in the middle of a charge
    setIn(760, 500, 900, 75);
    waitCycles(2);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid-charge reset", 6'b000000);
    rstN = 1'b1;
    waitCycles(2);
    check("R2 after reset", 6'b101000);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule